// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog that software keeps alive by writing a reload register in a small register bank. Once armed, the countdown steps down by one on each pulse of an external tick-enable input. Every expiry is recorded in a status bit. The first expiry can raise a one-cycle system-management interrupt (SMI) pulse, and the countdown then restarts by itself. A second expiry in a row, with no reload write in between, asks for a platform reset. A strap input or a no-reboot input can block that request.

Software reaches the bank through a synchronous port of up to 16 bits. Each write takes effect at the clock edge where `wr_en_i` is high. A read registers the addressed value into `rdata_o` at the edge where `rd_en_i` is high. Reading the reload register while the countdown runs returns the live remaining count. Control register 1 holds a lock bit that software can set but cannot clear.

Top module: `wdog_two_stage`

Register map (4-bit address): 0 reload (16 bits, count field in bits 9:0), 1 timer value (10 bits), 2 control 1 (bit 0 halt, bit 1 lock, bits 7:0 writable), 3 control 2 (16 bits), 4 status 1 (bit 0 timeout, bit 1 software SMI, bit 2 interrupt), 5 status 2 (bit 0 second timeout, bit 1 boot), 6 data-in (8 bits), 7 data-out (8 bits), 8 message A, 9 message B, 10 watchdog scratch, 11 software IRQ-generate (all 8 bits). All other addresses read as 0.

## Requirements
- R1: After a synchronous reset the timer value reads 4, control 2 reads 0x0008, IRQ-generate reads 0x03, and every other register reads 0. The countdown is stopped, and `smi_o` and `rst_req_o` are low.
- R2: The countdown starts only on a write to reload or control 1. It starts only when the halt bit (control 1 bit 0) is clear, the timer value is greater than 1, and no reset request is pending. A timer value of 0 or 1 never starts it.
- R3: A write to reload clears the consecutive-timeout count. If the countdown may start, it loads the count and the reload register from the timer value. Otherwise it stores the written value and leaves the run state unchanged. A tick in the same cycle is dropped.
- R4: A write to control 1 stores bits 7:0. The lock bit (bit 1) stays 1 once set, until reset. After the write the countdown restarts from the timer value if it may start, and stops otherwise. A tick in the same cycle is dropped.
- R5: While running, each tick lowers the count by 1. The tick that finds the count at 1 is an expiry, so one period lasts exactly timer-value ticks. An expiry sets status 1 bit 0.
- R6: Each expiry increments the consecutive-timeout count. When the count reaches 2, status 2 bits 0 and 1 are set and the count returns to 0.
- R7: On that second expiry, if `strap_i` and `noreboot_i` are both low, `rst_req_o` rises one cycle later and stays high until reset. The countdown stops, the reload register is cleared, no SMI is produced, and the countdown cannot be restarted.
- R8: On any other expiry, `smi_o` pulses for one cycle if `smi_en_i` is high. The countdown then reloads from the timer value and continues. If the timer value is then below 2, the countdown stops and the reload register is cleared instead.
- R9: Reading reload while running returns the remaining count in bits 9:0 together with the stored bits 15:10. While stopped, the read returns the stored value.
- R10: A write to data-in stores the low byte, sets status 1 bit 1, and pulses `smi_o` one cycle later whatever `smi_en_i` is. A write to data-out stores the low byte and sets status 1 bit 2.
- R11: A write to status 1 stores the written value masked by 0x0007, and a write to status 2 masks by 0x0003. A bit that hardware sets in the same cycle wins over the written value.
- R12: `rdata_o` takes the addressed value, as it was before any same-cycle write, one cycle after `rd_en_i`, and holds it otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| tick_i | input | 1 | Countdown tick enable |
| strap_i | input | 1 | Strap that blocks the reset request when high |
| noreboot_i | input | 1 | Blocks the reset request when high |
| smi_en_i | input | 1 | Enables the SMI pulse on expiry |
| smi_o | output | 1 | One-cycle SMI pulse |
| rst_req_o | output | 1 | Sticky platform reset request |

## Verification
The hardest case to reach from the ports is a register write that lands in the same cycle as an expiry. Examples are a timer-value change just as the count passes 1, or a status write racing the hardware set. Directed sequences alone almost never line these up. The stimulus therefore adds a long random phase: small timer values, dense ticks, and writes spread over every address, with the strap and no-reboot inputs flipped between sections. This makes both same-cycle collisions and reset-request lockout occur many times. A behavioural model in the bench predicts every output on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_RELOAD = 4'd0;
  localparam logic [ADDR_W-1:0] A_TVAL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTL1   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CTL2   = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT1  = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT2  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DIN    = 4'd6;
  localparam logic [ADDR_W-1:0] A_DOUT   = 4'd7;
  localparam logic [ADDR_W-1:0] A_MSGA   = 4'd8;
  localparam logic [ADDR_W-1:0] A_MSGB   = 4'd9;
  localparam logic [ADDR_W-1:0] A_SCRCH  = 4'd10;
  localparam logic [ADDR_W-1:0] A_IRQGEN = 4'd11;

  localparam logic [DATA_W-1:0] CTL1_WMASK  = 16'h00FF;
  localparam logic [DATA_W-1:0] STAT1_WMASK = 16'h0007;
  localparam logic [DATA_W-1:0] STAT2_WMASK = 16'h0003;

  localparam int CTL1_HALT = 0;
  localparam int CTL1_LOCK = 1;
  localparam int S1_TMO    = 0;
  localparam int S1_SWSMI  = 1;
  localparam int S1_INT    = 2;
  localparam int S2_SECOND = 0;
  localparam int S2_BOOT   = 1;

  localparam logic [DATA_W-1:0] CTL2_RST   = 16'h0008;
  localparam logic [BYTE_W-1:0] IRQGEN_RST = 8'h03;
endpackage

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             sw_hit_i,
  input  logic             sw_load_i,
  input  logic             sw_stop_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             exp_halt_i,
  output logic             running_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign expire_o  = tick_i & run_q & (cnt_q == CNT_W'(1)) & ~sw_hit_i;
  assign running_o = run_q;
  assign count_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (sw_hit_i) begin
      if (sw_load_i) begin
        run_q <= 1'b1;
        cnt_q <= load_val_i;
      end else if (sw_stop_i) begin
        run_q <= 1'b0;
      end
    end else if (expire_o) begin
      if (exp_halt_i) run_q <= 1'b0;
      else            cnt_q <= load_val_i;
    end else if (tick_i && run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry #(
  parameter int TO_LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic clear_i,
  input  logic strap_i,
  input  logic noreboot_i,
  output logic second_o,
  output logic take_reset_o
);
  localparam int TO_W = $clog2(TO_LIMIT + 1);

  logic [TO_W-1:0] to_q;

  assign second_o     = expire_i & (to_q == TO_W'(TO_LIMIT - 1));
  assign take_reset_o = second_o & ~strap_i & ~noreboot_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) to_q <= '0;
    else if (expire_i)  to_q <= second_o ? '0 : to_q + TO_W'(1);
  end

  AST_TO_RANGE: assert property (@(posedge clk) disable iff (rst)
    to_q < TO_W'(TO_LIMIT)); // R6
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int TO_LIMIT = 2,
  parameter int TVAL_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              strap_i,
  input  logic              noreboot_i,
  input  logic              smi_en_i,
  output logic              smi_o,
  output logic              rst_req_o
);
  localparam int HI_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] rld_q, ctl1_q, ctl2_q, s1_q, s2_q;
  logic [CNT_W-1:0]  tval_q;
  logic [BYTE_W-1:0] din_q, dout_q, msga_q, msgb_q, scr_q, irq_q;
  logic              smi_q, req_q;
  logic [DATA_W-1:0] rdata_q;

  logic wr_rld, wr_ctl1, wr_s1, wr_s2, wr_din, wr_dout;
  logic [DATA_W-1:0] ctl1_wval, s1_next, s2_next, rld_view, rd_mux, tval_ext;
  logic tval_ok, sw_load, sw_stop, sw_hit, exp_halt;
  logic running, expire, second, take_reset;
  logic [CNT_W-1:0] count;

  assign wr_rld  = wr_en_i && addr_i == A_RELOAD;
  assign wr_ctl1 = wr_en_i && addr_i == A_CTL1;
  assign wr_s1   = wr_en_i && addr_i == A_STAT1;
  assign wr_s2   = wr_en_i && addr_i == A_STAT2;
  assign wr_din  = wr_en_i && addr_i == A_DIN;
  assign wr_dout = wr_en_i && addr_i == A_DOUT;

  assign ctl1_wval = (wdata_i & CTL1_WMASK) | (ctl1_q & (DATA_W'(1) << CTL1_LOCK));
  assign tval_ok   = tval_q > CNT_W'(1);
  assign tval_ext  = {{HI_W{1'b0}}, tval_q};
  assign sw_hit    = wr_rld | wr_ctl1;
  assign sw_load   = tval_ok & ~req_q &
                     ((wr_rld & ~ctl1_q[CTL1_HALT]) | (wr_ctl1 & ~ctl1_wval[CTL1_HALT]));
  assign sw_stop   = wr_ctl1 & ~sw_load;
  assign exp_halt  = take_reset | ~tval_ok;

  wdog_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk(clk), .rst(rst), .tick_i(tick_i), .sw_hit_i(sw_hit),
    .sw_load_i(sw_load), .sw_stop_i(sw_stop), .load_val_i(tval_q),
    .exp_halt_i(exp_halt), .running_o(running), .count_o(count),
    .expire_o(expire)
  );

  wdog_expiry #(.TO_LIMIT(TO_LIMIT)) u_exp (
    .clk(clk), .rst(rst), .expire_i(expire), .clear_i(wr_rld),
    .strap_i(strap_i), .noreboot_i(noreboot_i),
    .second_o(second), .take_reset_o(take_reset)
  );

  always_comb begin
    s1_next = wr_s1 ? (wdata_i & STAT1_WMASK) : s1_q;
    s1_next[S1_TMO]   = s1_next[S1_TMO]   | expire;
    s1_next[S1_SWSMI] = s1_next[S1_SWSMI] | wr_din;
    s1_next[S1_INT]   = s1_next[S1_INT]   | wr_dout;
    s2_next = wr_s2 ? (wdata_i & STAT2_WMASK) : s2_q;
    s2_next[S2_SECOND] = s2_next[S2_SECOND] | second;
    s2_next[S2_BOOT]   = s2_next[S2_BOOT]   | second;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q  <= '0;
      tval_q <= CNT_W'(TVAL_RST);
      ctl1_q <= '0;
      ctl2_q <= CTL2_RST;
      s1_q   <= '0;
      s2_q   <= '0;
      din_q  <= '0;
      dout_q <= '0;
      msga_q <= '0;
      msgb_q <= '0;
      scr_q  <= '0;
      irq_q  <= IRQGEN_RST;
      smi_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      s1_q  <= s1_next;
      s2_q  <= s2_next;
      smi_q <= wr_din | (expire & ~take_reset & smi_en_i);
      if (take_reset) req_q <= 1'b1;
      if (wr_rld)                  rld_q <= sw_load ? tval_ext : wdata_i;
      else if (wr_ctl1 && sw_load) rld_q <= tval_ext;
      else if (expire)             rld_q <= exp_halt ? '0 : tval_ext;
      if (wr_ctl1) ctl1_q <= ctl1_wval;
      if (wr_en_i) begin
        case (addr_i)
          A_TVAL:   tval_q <= wdata_i[CNT_W-1:0];
          A_CTL2:   ctl2_q <= wdata_i;
          A_DIN:    din_q  <= wdata_i[BYTE_W-1:0];
          A_DOUT:   dout_q <= wdata_i[BYTE_W-1:0];
          A_MSGA:   msga_q <= wdata_i[BYTE_W-1:0];
          A_MSGB:   msgb_q <= wdata_i[BYTE_W-1:0];
          A_SCRCH:  scr_q  <= wdata_i[BYTE_W-1:0];
          A_IRQGEN: irq_q  <= wdata_i[BYTE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign rld_view = running ? {rld_q[DATA_W-1:CNT_W], count} : rld_q;

  always_comb begin
    case (addr_i)
      A_RELOAD: rd_mux = rld_view;
      A_TVAL:   rd_mux = tval_ext;
      A_CTL1:   rd_mux = ctl1_q;
      A_CTL2:   rd_mux = ctl2_q;
      A_STAT1:  rd_mux = s1_q;
      A_STAT2:  rd_mux = s2_q;
      A_DIN:    rd_mux = DATA_W'(din_q);
      A_DOUT:   rd_mux = DATA_W'(dout_q);
      A_MSGA:   rd_mux = DATA_W'(msga_q);
      A_MSGB:   rd_mux = DATA_W'(msgb_q);
      A_SCRCH:  rd_mux = DATA_W'(scr_q);
      A_IRQGEN: rd_mux = DATA_W'(irq_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign smi_o     = smi_q;
  assign rst_req_o = req_q;

  AST_START_GUARD: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> (!ctl1_q[CTL1_HALT] && tval_q > CNT_W'(1) && !req_q)); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctl1_q[CTL1_LOCK] |=> ctl1_q[CTL1_LOCK]); // R4
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    req_q |=> req_q); // R7
  AST_REQ_STOPS: assert property (@(posedge clk) disable iff (rst)
    req_q |-> !running); // R7
endmodule

// File: tb/wdog_two_stage_bench.sv
`timescale 1ns/1ps
module wdog_two_stage_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic strap = 1'b0, noreboot = 1'b0, smi_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic smi, rst_req;

  always #10 clk = ~clk;

  wdog_two_stage u_wdog_two_stage (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .strap_i(strap),
    .noreboot_i(noreboot), .smi_en_i(smi_en), .smi_o(smi), .rst_req_o(rst_req)
  );

  int vectors = 0, misses = 0, cycles = 0;
  string cur_req = "R1";

  int m_rld, m_tval, m_ctl1, m_ctl2, m_s1, m_s2, m_din, m_dout;
  int m_ma, m_mb, m_scr, m_irq, m_cnt, m_to, m_rdata;
  bit m_run, m_req, m_smi;

  function automatic int model_read(int a);
    case (a)
      0: return m_run ? ((m_rld & 'hFC00) | m_cnt) : m_rld;
      1: return m_tval;  2: return m_ctl1; 3: return m_ctl2;
      4: return m_s1;    5: return m_s2;   6: return m_din;
      7: return m_dout;  8: return m_ma;   9: return m_mb;
      10: return m_scr;  11: return m_irq;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    int tv0;
    bit hit, ex, take, ns;
    if (rst) begin
      m_rld = 0; m_tval = 4; m_ctl1 = 0; m_ctl2 = 8; m_s1 = 0; m_s2 = 0;
      m_din = 0; m_dout = 0; m_ma = 0; m_mb = 0; m_scr = 0; m_irq = 3;
      m_cnt = 0; m_to = 0; m_rdata = 0; m_run = 0; m_req = 0; m_smi = 0;
      return;
    end
    tv0 = m_tval; ns = 0;
    if (rd_en) m_rdata = model_read(int'(addr));
    hit = wr_en && (addr == 0 || addr == 2);
    ex  = tick && m_run && m_cnt == 1 && !hit;
    if (wr_en) begin
      case (int'(addr))
        0: begin
          m_to = 0;
          if (!(m_ctl1 & 1) && tv0 > 1 && !m_req) begin m_rld = tv0; m_cnt = tv0; m_run = 1; end
          else m_rld = int'(wdata);
        end
        1: m_tval = int'(wdata) & 'h3FF;
        2: begin
          m_ctl1 = (int'(wdata) & 'hFF) | (m_ctl1 & 2);
          if (!(m_ctl1 & 1) && tv0 > 1 && !m_req) begin m_rld = tv0; m_cnt = tv0; m_run = 1; end
          else m_run = 0;
        end
        3: m_ctl2 = int'(wdata);
        4: m_s1 = int'(wdata) & 7;
        5: m_s2 = int'(wdata) & 3;
        6: begin m_din = int'(wdata) & 'hFF; m_s1 |= 2; ns = 1; end
        7: begin m_dout = int'(wdata) & 'hFF; m_s1 |= 4; end
        8: m_ma = int'(wdata) & 'hFF;
        9: m_mb = int'(wdata) & 'hFF;
        10: m_scr = int'(wdata) & 'hFF;
        11: m_irq = int'(wdata) & 'hFF;
        default: ;
      endcase
    end
    if (ex) begin
      m_s1 |= 1; m_to++; take = 0;
      if (m_to == 2) begin m_s2 |= 3; m_to = 0; take = !strap && !noreboot; end
      if (take) begin m_req = 1; m_run = 0; m_rld = 0; end
      else begin
        if (smi_en) ns = 1;
        if (tv0 > 1) begin m_rld = tv0; m_cnt = tv0; end
        else begin m_run = 0; m_rld = 0; end
      end
    end else if (tick && m_run && !hit) m_cnt--;
    m_smi = ns;
  endtask

  always @(posedge clk) begin
    model_step();
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL %s watchdog expired: actual=hung expected=done", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // Every-cycle comparison against the behavioural model.
  always @(negedge clk) begin
    vectors++;
    if (rdata !== m_rdata[15:0] || smi !== m_smi || rst_req !== m_req) begin
      misses++;
      $display("FAIL %s t=%0t rdata/smi/req actual=%h/%b/%b expected=%h/%b/%b",
               cur_req, $time, rdata, smi, rst_req, m_rdata[15:0], m_smi, m_req);
    end
  end

  task automatic step(bit w, bit r, int a, int d, bit t);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 4'(a); wdata = 16'(d); tick = t;
  endtask
  task automatic wr(int a, int d); step(1, 0, a, d, 0); endtask
  task automatic rd(int a);        step(0, 1, a, 0, 0); endtask
  task automatic ticks(int n);     for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1); endtask
  task automatic idle(int n);      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0); endtask
  task automatic do_reset();
    @(negedge clk); rst = 1; wr_en = 0; rd_en = 0; tick = 0;
    @(negedge clk); rst = 0;
  endtask
  task automatic read_all(); for (int a = 0; a < 16; a++) rd(a); endtask

  initial begin
    idle(2);
    do_reset();
    cur_req = "R1"; read_all();
    cur_req = "R12"; rd(13); rd(15); idle(1);

    cur_req = "R2"; wr(0, 16'h1234); rd(0); ticks(3); rd(0);
    wr(1, 1); wr(0, 16'hABCD); rd(0); ticks(3); rd(0);
    wr(1, 0); wr(2, 0); rd(0);
    wr(1, 6); wr(2, 1); wr(0, 7); ticks(2); rd(0);

    cur_req = "R4"; wr(2, 16'hFF02); rd(2); wr(2, 0); rd(2); rd(0);
    cur_req = "R9"; ticks(2); rd(0); step(0, 1, 0, 0, 1); rd(0);

    cur_req = "R5"; strap = 1; smi_en = 1;
    wr(0, 0); ticks(5); rd(4); rd(0);
    cur_req = "R8"; ticks(6); rd(4); rd(5); ticks(12); rd(0);
    cur_req = "R6"; rd(5); wr(5, 0); rd(5);
    cur_req = "R3"; ticks(5); wr(0, 0); ticks(5); rd(5); step(1, 0, 0, 0, 1); rd(0);
    cur_req = "R8"; wr(1, 1); ticks(8); rd(0); rd(4);

    do_reset();
    cur_req = "R10"; wr(6, 16'h1A5); rd(6); rd(4); wr(7, 16'h33); rd(7); rd(4);
    cur_req = "R11"; wr(4, 16'hFFFF); rd(4); wr(5, 16'hFFFF); rd(5); wr(4, 0); rd(4);
    wr(8, 16'h11); wr(9, 16'h22); wr(10, 16'h33); wr(11, 16'h44); wr(3, 16'hBEEF);
    for (int a = 8; a < 12; a++) rd(a);
    rd(3);

    cur_req = "R7"; strap = 0; noreboot = 0; smi_en = 1;
    wr(1, 3); wr(0, 0); ticks(7); rd(0); rd(5);
    wr(0, 0); wr(2, 0); ticks(4); rd(0);
    do_reset();
    noreboot = 1; wr(1, 2); wr(0, 0); ticks(9); rd(5);

    cur_req = "R11";
    for (int n = 0; n < 12000; n++) begin
      int pick;
      if (n % 400 == 0) begin
        do_reset();
        strap = 1'($urandom_range(0, 1));
        noreboot = 1'($urandom_range(0, 1));
        smi_en = 1'($urandom_range(0, 1));
      end
      pick = $urandom_range(0, 9);
      if (pick < 3) begin
        int a = $urandom_range(0, 12);
        int d = (a == 1) ? $urandom_range(0, 7) :
                (a == 2) ? ($urandom_range(0, 3) & 1 ? 1 : $urandom_range(0, 255) & 'hFE) :
                $urandom_range(0, 65535);
        step(1, 1'($urandom_range(0, 1)), a, d, 1'($urandom_range(0, 1)));
      end else begin
        step(0, 1'($urandom_range(0, 1)), $urandom_range(0, 15), 0,
             1'($urandom_range(0, 3) != 0));
      end
    end
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule